// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the data-register side of a boundary-scan test port. It sits between a chip's core logic and its pads as one long serial chain of typed cells. Observe-only cells watch plain input pads. Bidirectional cells share one output-enable cell. Two-state cells drive dedicated outputs. Spare cells carry no pad. A separate port controller supplies the strobes: a capture pulse, a shift enable, an update pulse and a test-mode select. This block only moves and holds bits.

On a capture, every cell loads the value it observes, all in the same cycle. While shifting, the chain moves one place toward the serial output on each rising test-clock edge. On an update, the bits now in the chain are copied into hold latches on the falling edge. In external-test mode, the bidirectional and output pads are driven from those latches. The one shared control latch gates the output enable of every bidirectional pad. In normal mode, the core drives the pads directly and the latches are only kept.

The cell order, counted from the serial output, is: input cells, then bidirectional cells, then two-state output cells, then the control cell, then the spare cells. The default sizes are 66 inputs, 36 bidirectional pins, 2 outputs and 2 spares, which makes 107 cells.

Top module: `bsr_chain`

## Requirements
- R1: A synchronous reset (rst high at a rising tck edge) clears every chain bit. Reset at a falling tck edge clears every hold latch, control included. After reset, with ext_test=1, all bd_pin_oe bits are 0 and all bd_pin_out and pin_out2 bits are 0.
- R2: On a rising tck edge with cap_en=1, each cell loads its observed value. Cell i (i < N_IN) loads pin_in[i]. Cell N_IN+j loads bd_pin_in[j]. Cell N_IN+N_IO+k loads the value currently on pin_out2[k]. Cell N_IN+N_IO+N_OUT2 (the control cell) loads its own hold latch. The spare cells load 0.
- R3: On a rising tck edge with shf_en=1 and cap_en=0, cell n takes the old value of cell n+1. The top cell takes scan_in. scan_out always shows cell 0.
- R4: Hold latches load the chain contents on a falling tck edge where upd_en=1. At all other times they keep their value, including while the chain shifts.
- R5: With ext_test=1, bd_pin_out[j] equals the hold latch of cell N_IN+j.
- R6: With ext_test=1, every bd_pin_oe bit equals the control hold latch. A 0 in that latch turns every bidirectional output off.
- R7: With ext_test=1, pin_out2[k] equals the hold latch of cell N_IN+N_IO+k.
- R8: With ext_test=0, bd_pin_out, bd_pin_oe and pin_out2 follow core_io_out, core_io_oe and core_out2. The hold latches are kept and take effect again when ext_test returns to 1.
- R9: core_in always equals pin_in, and core_io_in always equals bd_pin_in, in every mode. Input cells never drive anything.
- R10: With cap_en=0 and shf_en=0, the chain keeps its contents across rising tck edges, whatever scan_in does.
- R11: When cap_en and shf_en are both 1 on the same edge, the capture wins and the chain loads the observed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the chain moves on the rising edge, the hold latches on the falling edge |
| rst | input | 1 | Synchronous active-high test reset |
| cap_en | input | 1 | Parallel capture strobe |
| shf_en | input | 1 | Shift enable |
| upd_en | input | 1 | Update strobe for the hold latches |
| ext_test | input | 1 | 1 = pads are driven from the hold latches |
| scan_in | input | 1 | Serial data into the top cell |
| scan_out | output | 1 | Serial data from cell 0 |
| pin_in | input | N_IN | Input pad values |
| core_in | output | N_IN | Input pad values passed on to the core |
| core_io_out | input | N_IO | Core output data for the bidirectional pads |
| core_io_oe | input | N_IO | Core output enables for the bidirectional pads |
| core_io_in | output | N_IO | Bidirectional pad values passed on to the core |
| bd_pin_out | output | N_IO | Output data to the bidirectional pads |
| bd_pin_oe | output | N_IO | Output enables to the bidirectional pads |
| bd_pin_in | input | N_IO | Values read back from the bidirectional pads |
| core_out2 | input | N_OUT2 | Core data for the two-state outputs |
| pin_out2 | output | N_OUT2 | Two-state output pad values |

## Verification
The bench uses a reduced chain of 4 inputs, 3 bidirectional pins, 2 outputs and 2 spares. Over this chain it sweeps every combination of input-pad values through the capture path. A word captured in normal mode shows that each cell samples its own pad and not a neighbour's. A word captured in external-test mode shows that the output cells and the control cell read back the hold latches. It then loads sixteen computed update patterns, with the control bit alternating. This separates the driven data from the shared enable, and both of them from core data. Idle, shift-without-update and capture-with-shift sequences tell apart holding the chain, holding the latches and the capture priority.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    CK_INPUT,
    CK_IO,
    CK_OUT2,
    CK_CTRL,
    CK_SPARE
  } cell_kind_e;

  // Chain layout from the serial output end: inputs, io, out2, control, spares.
  function automatic cell_kind_e kind_of(input int idx, input int n_in,
                                         input int n_io, input int n_out2);
    if (idx < n_in)                     return CK_INPUT;
    if (idx < n_in + n_io)              return CK_IO;
    if (idx < n_in + n_io + n_out2)     return CK_OUT2;
    if (idx == n_in + n_io + n_out2)    return CK_CTRL;
    return CK_SPARE;
  endfunction

endpackage

// File: rtl/bsr_shift_core.sv
module bsr_shift_core #(
  parameter int LEN = 107
) (
  input  logic           tck,
  input  logic           rst,
  input  logic           cap_en,
  input  logic           shf_en,
  input  logic           scan_in,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] chain,
  output logic           scan_out
);

  always_ff @(posedge tck) begin
    if (rst)
      chain <= '0;
    else if (cap_en)
      chain <= cap_vec;
    else if (shf_en)
      chain <= {scan_in, chain[LEN-1:1]};
  end

  assign scan_out = chain[0];

  // R3: one step toward the serial output per shift edge
  assert_shift_step_R3: assert property (@(posedge tck) disable iff (rst)
    (shf_en && !cap_en) |=> (chain[LEN-1] == $past(scan_in)) &&
                            (chain[LEN-2:0] == $past(chain[LEN-1:1])));

  // R10: no strobe, no change
  assert_chain_hold_R10: assert property (@(posedge tck) disable iff (rst)
    (!shf_en && !cap_en) |=> $stable(chain));

  // R11: capture wins over a simultaneous shift
  assert_cap_prio_R11: assert property (@(posedge tck) disable iff (rst)
    (cap_en && shf_en) |=> chain == $past(cap_vec));

endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank #(
  parameter int W = 39
) (
  input  logic         tck,
  input  logic         rst,
  input  logic         upd_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Falling-edge latches; reset value 0 is also the safe control value.
  always_ff @(negedge tck) begin
    if (rst)
      q <= '0;
    else if (upd_en)
      q <= d;
  end

  assert_upd_load_R4: assert property (@(negedge tck) disable iff (rst)
    upd_en |=> q == $past(d));

  assert_upd_keep_R4: assert property (@(negedge tck) disable iff (rst)
    !upd_en |=> $stable(q));

endmodule

// File: rtl/bsr_io_drv.sv
module bsr_io_drv #(
  parameter int N = 36
) (
  input  logic         ext_test,
  input  logic [N-1:0] upd_data,
  input  logic         ctrl_en,
  input  logic [N-1:0] core_out,
  input  logic [N-1:0] core_oe,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] core_in
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_comb begin
      if (ext_test) begin
        pin_out[g] = upd_data[g];
        pin_oe[g]  = ctrl_en;
      end else begin
        pin_out[g] = core_out[g];
        pin_oe[g]  = core_oe[g];
      end
    end
  end

  assign core_in = pin_in;

endmodule

// File: rtl/bsr_out2_drv.sv
module bsr_out2_drv #(
  parameter int N = 2
) (
  input  logic         ext_test,
  input  logic [N-1:0] upd_data,
  input  logic [N-1:0] core_out,
  output logic [N-1:0] pin_out
);

  assign pin_out = ext_test ? upd_data : core_out;

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_IN   = 66,
  parameter int N_IO   = 36,
  parameter int N_OUT2 = 2,
  parameter int N_SPARE = 2
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              upd_en,
  input  logic              ext_test,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [N_IN-1:0]   pin_in,
  output logic [N_IN-1:0]   core_in,
  input  logic [N_IO-1:0]   core_io_out,
  input  logic [N_IO-1:0]   core_io_oe,
  output logic [N_IO-1:0]   core_io_in,
  output logic [N_IO-1:0]   bd_pin_out,
  output logic [N_IO-1:0]   bd_pin_oe,
  input  logic [N_IO-1:0]   bd_pin_in,
  input  logic [N_OUT2-1:0] core_out2,
  output logic [N_OUT2-1:0] pin_out2
);

  localparam int IO_BASE  = N_IN;
  localparam int OUT_BASE = N_IN + N_IO;
  localparam int CTRL_POS = N_IN + N_IO + N_OUT2;
  localparam int LEN      = CTRL_POS + 1 + N_SPARE;
  localparam int UPD_W    = N_IO + N_OUT2 + 1;

  logic [LEN-1:0]   chain;
  logic [LEN-1:0]   cap_vec;
  logic [UPD_W-1:0] upd_q;
  logic [N_IO-1:0]  upd_io;
  logic [N_OUT2-1:0] upd_out2;
  logic             upd_ctrl;

  assign upd_io   = upd_q[N_IO-1:0];
  assign upd_out2 = upd_q[N_IO+N_OUT2-1:N_IO];
  assign upd_ctrl = upd_q[UPD_W-1];

  // Per-cell capture source, chosen by cell kind.
  for (genvar g = 0; g < LEN; g++) begin : g_cell
    localparam cell_kind_e KIND = kind_of(g, N_IN, N_IO, N_OUT2);
    if (KIND == CK_INPUT) begin : g_in
      assign cap_vec[g] = pin_in[g];
    end else if (KIND == CK_IO) begin : g_io
      assign cap_vec[g] = bd_pin_in[g-IO_BASE];
    end else if (KIND == CK_OUT2) begin : g_o2
      assign cap_vec[g] = pin_out2[g-OUT_BASE];
    end else if (KIND == CK_CTRL) begin : g_ctl
      assign cap_vec[g] = upd_ctrl;
    end else begin : g_sp
      assign cap_vec[g] = 1'b0;
    end
  end

  bsr_shift_core #(.LEN(LEN)) u_shift (
    .tck      (tck),
    .rst      (rst),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .scan_in  (scan_in),
    .cap_vec  (cap_vec),
    .chain    (chain),
    .scan_out (scan_out)
  );

  // Hold latches cover io, out2 and control cells (contiguous in the chain).
  bsr_update_bank #(.W(UPD_W)) u_upd (
    .tck    (tck),
    .rst    (rst),
    .upd_en (upd_en),
    .d      (chain[CTRL_POS:IO_BASE]),
    .q      (upd_q)
  );

  bsr_io_drv #(.N(N_IO)) u_io (
    .ext_test (ext_test),
    .upd_data (upd_io),
    .ctrl_en  (upd_ctrl),
    .core_out (core_io_out),
    .core_oe  (core_io_oe),
    .pin_in   (bd_pin_in),
    .pin_out  (bd_pin_out),
    .pin_oe   (bd_pin_oe),
    .core_in  (core_io_in)
  );

  bsr_out2_drv #(.N(N_OUT2)) u_out2 (
    .ext_test (ext_test),
    .upd_data (upd_out2),
    .core_out (core_out2),
    .pin_out  (pin_out2)
  );

  assign core_in = pin_in;

  // R6: a safe control latch keeps every bidirectional pad off in test mode
  assert_safe_tristate_R6: assert property (@(posedge tck) disable iff (rst)
    (ext_test && !upd_ctrl) |-> bd_pin_oe == '0);

  // R8: functional mode enables come from the core
  assert_func_oe_R8: assert property (@(posedge tck) disable iff (rst)
    !ext_test |-> bd_pin_oe == core_io_oe);

endmodule

// File: tb/bsr_chain_tb_top.sv
module bsr_chain_tb_top;

  localparam int NI  = 4;
  localparam int NIO = 3;
  localparam int NO2 = 2;
  localparam int NSP = 2;
  localparam int LEN = NI + NIO + NO2 + 1 + NSP;
  localparam int CP  = NI + NIO + NO2;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 0, shf_en = 0, upd_en = 0, ext_test = 0, scan_in = 0;
  logic scan_out;
  logic [NI-1:0]  pin_in = '0;
  logic [NI-1:0]  core_in;
  logic [NIO-1:0] core_io_out = '0, core_io_oe = '0, core_io_in;
  logic [NIO-1:0] bd_pin_out, bd_pin_oe, bd_pin_in = '0;
  logic [NO2-1:0] core_out2 = '0, pin_out2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 tck = ~tck;

  bsr_chain #(.N_IN(NI), .N_IO(NIO), .N_OUT2(NO2), .N_SPARE(NSP)) dut_i (
    .tck(tck), .rst(rst), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
    .ext_test(ext_test), .scan_in(scan_in), .scan_out(scan_out),
    .pin_in(pin_in), .core_in(core_in),
    .core_io_out(core_io_out), .core_io_oe(core_io_oe), .core_io_in(core_io_in),
    .bd_pin_out(bd_pin_out), .bd_pin_oe(bd_pin_oe), .bd_pin_in(bd_pin_in),
    .core_out2(core_out2), .pin_out2(pin_out2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #2;
  endtask

  task automatic shift_word(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    for (int i = 0; i < LEN; i++) begin
      scan_in = din[i];
      dout[i] = scan_out;
      shf_en = 1'b1;
      step();
    end
    shf_en = 1'b0;
  endtask

  task automatic capture();
    cap_en = 1'b1;
    step();
    cap_en = 1'b0;
  endtask

  task automatic update();
    upd_en = 1'b1;
    step();
    upd_en = 1'b0;
  endtask

  function automatic logic [LEN-1:0] cap_exp(input logic [NI-1:0] pi, input logic [NIO-1:0] bi,
                                             input logic [NO2-1:0] o2, input logic ctl);
    return {{NSP{1'b0}}, ctl, o2, bi, pi};
  endfunction

  task automatic check_pads(input string req, input logic [LEN-1:0] p);
    check({req, " io data"}, 32'(bd_pin_out), 32'(p[NI+NIO-1:NI]));
    check({req, " io oe"},   32'(bd_pin_oe),  32'({NIO{p[CP]}}));
    check({req, " out2"},    32'(pin_out2),   32'(p[CP-1:NI+NIO]));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] dout, p, q, cv;
    step(); step(); step();
    rst = 1'b0;

    // R1: reset state
    ext_test = 1'b1;
    #1;
    check("R1 scan_out", 32'(scan_out), 0);
    check("R1 oe", 32'(bd_pin_oe), 0);
    check("R1 io data", 32'(bd_pin_out), 0);
    check("R1 out2", 32'(pin_out2), 0);
    shift_word('0, dout);
    check("R1 chain", 32'(dout), 0);
    ext_test = 1'b0;

    // R9: pass-through of input pads in both modes
    for (int v = 0; v < 32; v++) begin
      pin_in = v[3:0];
      bd_pin_in = v[2:0];
      ext_test = v[4];
      #1;
      check("R9 core_in", 32'(core_in), 32'(v[3:0]));
      check("R9 core_io_in", 32'(core_io_in), 32'(v[2:0]));
    end
    ext_test = 1'b0;

    // R2 + R3: capture sweep in normal mode, control latch still 0
    for (int v = 0; v < 32; v++) begin
      pin_in = v[3:0];
      bd_pin_in = v[2:0] ^ 3'b101;
      core_out2 = v[4:3];
      capture();
      shift_word('0, dout);
      check("R2 capture func", 32'(dout),
            32'(cap_exp(v[3:0], v[2:0] ^ 3'b101, v[4:3], 1'b0)));
    end

    // R3: pattern shifted in comes back out on the next pass
    shift_word(12'hA5C, dout);
    shift_word(12'h3C9, dout);
    check("R3 shift through", 32'(dout), 32'h0A5C);
    shift_word('0, dout);
    check("R3 shift second", 32'(dout), 32'h03C9);

    // R5, R6, R7: update patterns driven in test mode, control alternating
    for (int k = 0; k < 16; k++) begin
      p = 12'((k * 32'h9B7 + 32'h35) & 32'hFFF);
      p[CP] = k[0];
      shift_word(p, dout);
      update();
      ext_test = 1'b1;
      #1;
      check_pads("R5 R6 R7 extest", p);
      if (!p[CP]) check("R6 safe off", 32'(bd_pin_oe), 0);
      // R2: in test mode out2 and control cells read back the latches
      pin_in = k[3:0];
      bd_pin_in = k[2:0];
      capture();
      shift_word('0, dout);
      check("R2 capture extest", 32'(dout),
            32'(cap_exp(k[3:0], k[2:0], p[CP-1:NI+NIO], p[CP])));
      ext_test = 1'b0;
    end

    // R4: latches keep their value during shifting, load only on update
    p = 12'h2B6;
    p[CP] = 1'b1;
    shift_word(p, dout);
    update();
    q = 12'h549;
    ext_test = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      scan_in = q[i];
      shf_en = 1'b1;
      step();
      if (i == LEN / 2) check_pads("R4 mid shift", p);
    end
    shf_en = 1'b0;
    #1;
    check_pads("R4 after shift", p);
    update();
    #1;
    check_pads("R4 after update", q);

    // R8: normal mode follows the core, latches survive the excursion
    ext_test = 1'b0;
    for (int v = 0; v < 8; v++) begin
      core_io_out = v[2:0];
      core_io_oe = ~v[2:0];
      core_out2 = v[1:0] ^ 2'b10;
      #1;
      check("R8 io data", 32'(bd_pin_out), 32'(v[2:0]));
      check("R8 io oe", 32'(bd_pin_oe), 32'(3'(~v[2:0])));
      check("R8 out2", 32'(pin_out2), 32'(v[1:0] ^ 2'b10));
      step();
    end
    ext_test = 1'b1;
    #1;
    check_pads("R8 latches kept", q);
    ext_test = 1'b0;

    // R10: idle edges leave the chain untouched
    p = 12'hD27;
    shift_word(p, dout);
    for (int i = 0; i < 7; i++) begin
      scan_in = i[0];
      step();
    end
    shift_word('0, dout);
    check("R10 hold", 32'(dout), 32'(p));

    // R11: capture beats shift on the same edge
    shift_word(12'hFFF, dout);
    pin_in = 4'h6;
    bd_pin_in = 3'h5;
    core_out2 = 2'h1;
    cv = cap_exp(4'h6, 3'h5, 2'h1, q[CP]);
    cap_en = 1'b1;
    shf_en = 1'b1;
    scan_in = 1'b1;
    step();
    cap_en = 1'b0;
    shf_en = 1'b0;
    shift_word('0, dout);
    check("R11 priority", 32'(dout), 32'(cv));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule